// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block merges many level-sensitive interrupt sources into a smaller set of parent interrupt lines. The sources are split into groups of eight. Each group has its own output line. A group's line is high while any enabled source in that group is high. The parent controller sees one line per group. Software then reads a status word to find which sources in that group are pending.

Every four consecutive groups share one 32-bit register bank, and the banks repeat every 16 bytes. Each bank has four word offsets:

- 0x0: a write-one-to-set enable port. A read returns the current enables.
- 0x4: a write-one-to-clear enable port.
- 0x8: unmapped.
- 0xC: a read-only masked status word.

The sources are synchronized before use. A status bit follows its source level with no latching, so a source that drops clears its status bit without any write. Because the enables can be read back, software can save them and later restore them with a clear-all write followed by a set write.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every `irq_o` bit is 0, and every register reads 0.
- R2: A write to word offset 0x0 (`addr_i[3:2]`=0) of a bank sets each enable bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. A read of offset 0x0 returns the enable bits.
- R3: A write to word offset 0x4 (`addr_i[3:2]`=1) clears each enable bit whose data bit is 1 and leaves the other bits unchanged.
- R4: A read of offset 0xC (`addr_i[3:2]`=3) returns the synchronized source levels ANDed with the enable bits. A bit is not latched: it returns to 0 when its source drops.
- R5: Source `src_i[8*g+i]` belongs to group g. Group g uses bits [8*(g%4)+7 : 8*(g%4)] of the bank at byte address 0x10*(g/4), which is selected by `addr_i[ADDR_W-1:4]`. `addr_i[1:0]` is ignored.
- R6: `irq_o[g]` is the OR of group g's eight masked status bits, registered once.
  - A source change shows on `irq_o` at the third rising edge after it.
  - An enable write shows on `irq_o` at the rising edge after the write edge.
- R7: Writes to offset 0x8, to offset 0xC and to banks beyond the last group have no effect. Reads of offset 0x8 and of such banks return 0. In a partly filled last bank, the bits of absent groups read 0 and cannot be set.
- R8: A saved offset-0x0 value is restored exactly by a clear-all write to 0x4 followed by a write of the saved value to 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | ADDR_W | Byte address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| src_i | input | NUM_GROUPS*8 | Level-sensitive interrupt sources |
| irq_o | output | NUM_GROUPS | One interrupt line per group |

## Verification
The bench builds the block with six groups and a 6-bit address. This gives one full bank, one bank holding only two groups, and two addressable banks that hold no groups at all. With that setup, the partial-bank masking and the out-of-range bank decode can be checked alongside the normal path. A 256-step sweep mixes partial clear and set masks with varied source patterns. After each step it compares every status word, enable word and interrupt line against a bench model of the enables. Separate checks cover the exact latency from source change to interrupt, dropping a source, the unmapped offsets, and save and restore.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam int unsigned SRC_PER_GRP  = 8;
  localparam int unsigned GRP_PER_BANK = 4;
  localparam int unsigned BANK_BITS    = SRC_PER_GRP * GRP_PER_BANK;
  localparam int unsigned STRIDE_LOG2  = 4;

  typedef enum logic [1:0] {
    OFS_SET  = 2'd0,
    OFS_CLR  = 2'd1,
    OFS_NONE = 2'd2,
    OFS_STAT = 2'd3
  } ofs_e;
endpackage

// File: rtl/cmb_sync.sv
module cmb_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cmb_bank.sv
module cmb_bank #(
  parameter int unsigned GRP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic [31:0]       wdata_i,
  input  logic [GRP*8-1:0]  lvl_i,
  output logic [31:0]       en_o,
  output logic [31:0]       stat_o,
  output logic [GRP-1:0]    irq_o
);
  localparam int unsigned LW = GRP * 8;

  logic [LW-1:0]  en_q;
  logic [LW-1:0]  stat;
  logic [LW-1:0]  wd;
  logic [GRP-1:0] irq_q;

  assign wd = wdata_i[LW-1:0];

  if (LW < 32) begin : g_pad
    logic unused_wd;
    assign unused_wd = ^wdata_i[31:LW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= '0;
    else if (set_we_i) en_q <= en_q | wd;
    else if (clr_we_i) en_q <= en_q & ~wd;
  end

  assign stat = lvl_i & en_q;

  always_comb begin
    en_o             = '0;
    en_o[LW-1:0]     = en_q;
    stat_o           = '0;
    stat_o[LW-1:0]   = stat;
  end

  for (genvar g = 0; g < GRP; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[g] <= 1'b0;
      else         irq_q[g] <= |stat[g*8 +: 8];
    end

    // R6
    irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|stat[g*8 +: 8]) |=> irq_q[g]);
    // R6
    irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|stat[g*8 +: 8]) |=> !irq_q[g]);
  end

  assign irq_o = irq_q;

  // R2
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((en_q & $past(wd)) == $past(wd)));
  // R3
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((en_q & $past(wd)) == '0));
  // R7
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i) |=> $stable(en_q));
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import cmb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 20,
  parameter int unsigned ADDR_W     = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  input  logic [NUM_GROUPS*8-1:0]    src_i,
  output logic [NUM_GROUPS-1:0]      irq_o
);
  localparam int unsigned NSRC  = NUM_GROUPS * SRC_PER_GRP;
  localparam int unsigned NB    = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK;
  localparam int unsigned IDX_W = ADDR_W - STRIDE_LOG2;

  logic [NSRC-1:0]  lvl;
  logic [IDX_W-1:0] bank_idx;
  ofs_e             ofs;
  logic [31:0]      en_all   [NB];
  logic [31:0]      stat_all [NB];
  logic             unused_addr;

  assign bank_idx    = addr_i[ADDR_W-1:STRIDE_LOG2];
  assign ofs         = ofs_e'(addr_i[3:2]);
  assign unused_addr = ^addr_i[1:0];

  cmb_sync #(.W(NSRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (lvl)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int unsigned GRP =
      (NUM_GROUPS - b*GRP_PER_BANK >= GRP_PER_BANK) ? GRP_PER_BANK
                                                    : NUM_GROUPS - b*GRP_PER_BANK;
    logic hit;
    assign hit = wr_i && (bank_idx == IDX_W'(b));

    cmb_bank #(.GRP(GRP)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_we_i(hit && (ofs == OFS_SET)),
      .clr_we_i(hit && (ofs == OFS_CLR)),
      .wdata_i (wdata_i),
      .lvl_i   (lvl[b*BANK_BITS +: GRP*8]),
      .en_o    (en_all[b]),
      .stat_o  (stat_all[b]),
      .irq_o   (irq_o[b*GRP_PER_BANK +: GRP])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (bank_idx == IDX_W'(b)) begin
        case (ofs)
          OFS_SET:  rdata_o = en_all[b];
          OFS_STAT: rdata_o = stat_all[b];
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  // R7
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs == OFS_NONE || ofs == OFS_CLR) |-> (rdata_o == '0));
endmodule

// File: tb/sim_irq_group_combiner.sv
module sim_irq_group_combiner;
  localparam int NG = 6;
  localparam int AW = 6;
  localparam logic [63:0] VM = {16'h0, 48'hFFFF_FFFF_FFFF};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NG*8-1:0] src_i = '0;
  logic [NG-1:0] irq_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [63:0] en_m = '0;

  always #2.5 clk_i = ~clk_i;

  irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) u0 (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o, .src_i, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic apply_src(input logic [NG*8-1:0] v);
    @(negedge clk_i);
    src_i = v;
    repeat (3) @(negedge clk_i);
  endtask

  function automatic logic [31:0] exp_irq();
    logic [63:0] m;
    logic [31:0] r;
    m = en_m & {16'h0, src_i};
    r = '0;
    for (int g = 0; g < NG; g++) r[g] = |m[g*8 +: 8];
    return r;
  endfunction

  task automatic check_all(input string req);
    logic [31:0] d;
    logic [63:0] m;
    m = en_m & {16'h0, src_i};
    rd(6'h0C, d); check({req, " stat0"}, d, m[31:0]);
    rd(6'h1C, d); check({req, " stat1"}, d, m[63:32]);
    rd(6'h00, d); check({req, " en0"}, d, en_m[31:0]);
    rd(6'h10, d); check({req, " en1"}, d, en_m[63:32]);
    check({req, " irq"}, 32'(irq_o), exp_irq());
  endtask

  initial begin
    logic [31:0] d, saved;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(6'h00, d); check("R1 en0", d, 32'h0);
    rd(6'h10, d); check("R1 en1", d, 32'h0);
    rd(6'h0C, d); check("R1 stat0", d, 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);

    // R7 absent groups in partial bank
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_FFFF);
    en_m = VM;
    rd(6'h10, d); check("R7 partial bank", d, 32'h0000_FFFF);

    // R6 latency: source 13 lies in group 1
    @(negedge clk_i);
    src_i = 48'h0000_0000_2000;
    @(negedge clk_i); check("R6 lat1", 32'(irq_o), 32'h0);
    @(negedge clk_i); check("R6 lat2", 32'(irq_o), 32'h0);
    @(negedge clk_i); check("R6 lat3", 32'(irq_o), 32'h2);
    rd(6'h0C, d); check("R4 R5 stat src13", d, 32'h0000_2000);

    // R6 enable write latency: clear takes effect on irq one edge later
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = 6'h04; wdata_i = 32'h0000_2000;
    @(negedge clk_i);
    wr_i = 1'b0;
    check("R6 irq after clear", 32'(irq_o), 32'h2);
    @(negedge clk_i);
    check("R6 irq after clear next", 32'(irq_o), 32'h0);
    en_m[13] = 1'b0;

    // R4 no latch: drop the source
    wr(6'h00, 32'h0000_2000); en_m[13] = 1'b1;
    apply_src('0);
    check_all("R4 drop");

    // R3 clear all
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    en_m = '0;
    check_all("R3 clear all");

    // R2 R3 R4 R5 R6 sweep
    for (int k = 0; k < 256; k++) begin
      logic [7:0] kb;
      logic [31:0] s0, c0, s1, c1;
      logic [NG*8-1:0] sv;
      kb = 8'(k);
      s0 = {kb, 8'(kb*7), kb ^ 8'h5A, ~kb};
      c0 = {8'(kb*13), 8'(kb+3), kb ^ 8'hC3, 8'(kb*5)};
      s1 = {8'(kb*11), kb ^ 8'h96, 8'(kb*3), 8'(kb+77)};
      c1 = {kb, 8'(kb*9), ~kb, kb ^ 8'h3C};
      sv = 48'(k * 48'h9E37_79B9_7F4A) ^ {6{kb}};
      wr(6'h04, c0); wr(6'h14, c1);
      en_m = en_m & ~{c1, c0};
      wr(6'h00, s0); wr(6'h10, s1);
      en_m = (en_m | {s1, s0}) & VM;
      apply_src(sv);
      check_all("R2 R3 R4 R5 R6 sweep");
    end

    // R7 ignored writes and unmapped reads
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h34, 32'hFFFF_FFFF);
    check_all("R7 ignored writes");
    rd(6'h08, d); check("R7 rd 0x08", d, 32'h0);
    rd(6'h04, d); check("R7 rd 0x04", d, 32'h0);
    rd(6'h20, d); check("R7 rd 0x20", d, 32'h0);
    rd(6'h2C, d); check("R7 rd 0x2C", d, 32'h0);
    rd(6'h01, d); check("R5 low addr bits", d, en_m[31:0]);

    // R8 save and restore
    rd(6'h00, saved);
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h00, d); check("R8 cleared", d, 32'h0);
    wr(6'h00, saved);
    rd(6'h00, d); check("R8 restored", d, saved);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule